// File: doc/BRIEF.md
# Variable-Length Instruction Assembler

This unit sits between instruction memory and a decoder. It takes one byte per handshake from a valid/ready stream and looks only at the first byte of each instruction to decide whether the instruction is one byte long or three. A three-byte instruction carries a 16-bit word after its opcode. The unit collects that word with the first trailing byte as the low half and the second as the high half. Once the instruction is complete, the unit presents it as a single output beat. The beat holds the opcode, the operand word, the length, the address the instruction was fetched from, and the address that follows it.

The unit keeps its own instruction pointer. The pointer advances by the length of each instruction when that instruction is issued. A redirect input loads a new pointer value and discards any instruction that is only partly collected. An instruction that has already been issued and is waiting for the consumer is kept. The output register holds its contents under backpressure. No byte is taken while an issued instruction is waiting, or in a cycle where a redirect is present.

The opcode byte is split as class = bits [7:5], sub-field = bits [4:3], operand selector = bits [2:0]. Full decoding of the operation is left to the downstream decoder.

Top module: `vla_assembler`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and cur_ip equals RESET_IP (0 by default).
- R2: For an opcode whose class bits [7:5] are non-zero, the instruction is three bytes long when bits [2:0] are 101, 110 or 111. For any other value of bits [2:0] it is one byte long.
- R3: Every opcode of the form 00001xxx is a branch and is three bytes long.
- R4: Opcode 00010mmm follows the bits [2:0] rule of R2. Opcodes 00000xxx and 00011xxx are one byte long.
- R5: The operand is assembled little-endian: the first trailing byte is bits [7:0] and the second is bits [15:8]. For example, C6 00 10 yields operand 0x1000 and C6 00 20 yields 0x2000. A one-byte instruction reports operand 0.
- R6: out_len is 1 or 3. out_addr is the pointer value at which the opcode was taken. out_next_ip equals out_addr + out_len. cur_ip equals out_next_ip from the cycle the instruction is issued.
- R7: While out_valid is high and out_ready is low, all output fields stay unchanged and in_ready is 0. A beat with out_ready high clears out_valid.
- R8: While redir_valid is high, in_ready is 0. In the next cycle, cur_ip equals redir_addr and any partial instruction is discarded, so the next byte taken is treated as an opcode fetched at redir_addr.
- R9: Bytes are taken only on cycles where in_valid and in_ready are both high. Idle cycles of any length between bytes leave the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte stream valid |
| in_byte | input | BYTE_W | Byte from instruction memory |
| in_ready | output | 1 | Unit can take a byte this cycle |
| redir_valid | input | 1 | Load a new pointer and drop partial work |
| redir_addr | input | ADDR_W | New pointer value |
| out_valid | output | 1 | Assembled instruction present |
| out_ready | input | 1 | Consumer takes the instruction |
| out_opcode | output | BYTE_W | Opcode byte |
| out_operand | output | 2*BYTE_W | Operand word, zero for short instructions |
| out_len | output | 2 | Instruction length in bytes (1 or 3) |
| out_addr | output | ADDR_W | Fetch address of the opcode |
| out_next_ip | output | ADDR_W | Address following the instruction |
| cur_ip | output | ADDR_W | Current instruction pointer |

## Verification
The bench sends all 256 opcode values in turn. Each carries trailing bytes computed from the opcode, and the bench checks the length decision the moment the opcode is taken. A decoder that mistakes a selector value, misses the branch group, or treats the complement sub-group as a standalone opcode either issues early or stalls waiting for bytes that never come. A swapped byte order shows up as a wrong operand on every long instruction, and a pointer that advances by a fixed amount drifts away from the running expected address. The bench also drives junk bytes while an output is held and a redirect in the middle of an instruction. A unit that accepts bytes under backpressure, or keeps the stale low byte after a redirect, then misassembles the next instruction.

// File: rtl/vla_pkg.sv
package vla_pkg;

   typedef enum logic [1:0] {
      ST_OPCODE = 2'd0,
      ST_LOW    = 2'd1,
      ST_HIGH   = 2'd2
   } asm_state_t;

   localparam int unsigned LEN_SHORT = 1;
   localparam int unsigned LEN_LONG  = 3;

   // True when the opcode is followed by a 16-bit word.
   function automatic logic opcode_takes_word(input logic [7:0] op);
      logic mem_or_const;
      logic result;
      mem_or_const = (op[2:0] >= 3'd5);
      if (op[7:5] != 3'b000) begin
         result = mem_or_const;
      end else begin
         case (op[4:3])
            2'b01:   result = 1'b1;
            2'b10:   result = mem_or_const;
            default: result = 1'b0;
         endcase
      end
      return result;
   endfunction

endpackage

// File: rtl/vla_len_decode.sv
module vla_len_decode #(
   parameter int BYTE_W       = 8,
   parameter int DECODE_STYLE = 0
) (
   input  logic [BYTE_W-1:0] opcode,
   output logic              needs_word
);

   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("vla_len_decode: BYTE_W must be 8");
      end
      if (DECODE_STYLE != 0 && DECODE_STYLE != 1) begin : g_bad_style
         $error("vla_len_decode: DECODE_STYLE must be 0 or 1");
      end

      if (DECODE_STYLE == 0) begin : g_logic
         logic sel_addr;
         logic cls_zero;
         logic grp_branch;
         logic grp_unary;
         assign sel_addr   = opcode[2] & (opcode[1] | opcode[0]);
         assign cls_zero   = (opcode[7:5] == 3'b000);
         assign grp_branch = cls_zero & (opcode[4:3] == 2'b01);
         assign grp_unary  = cls_zero & (opcode[4:3] == 2'b10);
         assign needs_word = grp_branch | ((~cls_zero | grp_unary) & sel_addr);
      end else begin : g_table
         localparam int N_ENT = 1 << BYTE_W;
         logic [N_ENT-1:0] tbl;
         for (genvar i = 0; i < N_ENT; i++) begin : g_ent
            assign tbl[i] = vla_pkg::opcode_takes_word(8'(i));
         end
         assign needs_word = tbl[opcode];
      end
   endgenerate

endmodule

// File: rtl/vla_word_collect.sv
module vla_word_collect #(
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drop,
   input  logic              take_low,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [WORD_W-1:0] word_next
);

   logic [BYTE_W-1:0] low_q;

   always_ff @(posedge clk) begin
      if (!rst_n || drop) begin
         low_q <= '0;
      end else if (take_low) begin
         low_q <= byte_in;
      end
   end

   // High half arrives on the byte being taken now.
   assign word_next = {byte_in, low_q};

endmodule

// File: rtl/vla_ip_track.sv
module vla_ip_track #(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] RESET_IP = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redir_valid,
   input  logic [ADDR_W-1:0] redir_addr,
   input  logic              advance,
   input  logic [1:0]        step,
   output logic [ADDR_W-1:0] ip
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ip <= RESET_IP;
      end else if (redir_valid) begin
         ip <= redir_addr;
      end else if (advance) begin
         ip <= ip + ADDR_W'(step);
      end
   end

endmodule

// File: rtl/vla_assembler.sv
module vla_assembler #(
   parameter int BYTE_W       = 8,
   parameter int ADDR_W       = 16,
   parameter logic [ADDR_W-1:0] RESET_IP = '0,
   parameter int DECODE_STYLE = 0,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   output logic              in_ready,
   input  logic              redir_valid,
   input  logic [ADDR_W-1:0] redir_addr,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BYTE_W-1:0] out_opcode,
   output logic [WORD_W-1:0] out_operand,
   output logic [1:0]        out_len,
   output logic [ADDR_W-1:0] out_addr,
   output logic [ADDR_W-1:0] out_next_ip,
   output logic [ADDR_W-1:0] cur_ip
);
   import vla_pkg::*;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("vla_assembler: ADDR_W too small");
      end
   endgenerate

   asm_state_t        state_q;
   logic [BYTE_W-1:0] op_q;
   logic              take;
   logic              needs_word;
   logic              emit_short;
   logic              emit_long;
   logic              emit;
   logic [1:0]        emit_len;
   logic [WORD_W-1:0] word_next;

   assign in_ready   = !out_valid && !redir_valid;
   assign take       = in_valid && in_ready;
   assign emit_short = take && (state_q == ST_OPCODE) && !needs_word;
   assign emit_long  = take && (state_q == ST_HIGH);
   assign emit       = emit_short || emit_long;
   assign emit_len   = emit_long ? 2'(LEN_LONG) : 2'(LEN_SHORT);

   vla_len_decode #(
      .BYTE_W      (BYTE_W),
      .DECODE_STYLE(DECODE_STYLE)
   ) u_len (
      .opcode    (in_byte),
      .needs_word(needs_word)
   );

   vla_word_collect #(
      .BYTE_W(BYTE_W)
   ) u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .drop     (redir_valid),
      .take_low (take && (state_q == ST_LOW)),
      .byte_in  (in_byte),
      .word_next(word_next)
   );

   vla_ip_track #(
      .ADDR_W  (ADDR_W),
      .RESET_IP(RESET_IP)
   ) u_ip (
      .clk        (clk),
      .rst_n      (rst_n),
      .redir_valid(redir_valid),
      .redir_addr (redir_addr),
      .advance    (emit),
      .step       (emit_len),
      .ip         (cur_ip)
   );

   // Sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_OPCODE;
         op_q    <= '0;
      end else if (redir_valid) begin
         state_q <= ST_OPCODE;
      end else if (take) begin
         case (state_q)
            ST_OPCODE: begin
               op_q    <= in_byte;
               state_q <= needs_word ? ST_LOW : ST_OPCODE;
            end
            ST_LOW:  state_q <= ST_HIGH;
            default: state_q <= ST_OPCODE;
         endcase
      end
   end

   // Output register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_opcode  <= '0;
         out_operand <= '0;
         out_len     <= '0;
         out_addr    <= '0;
      end else if (emit) begin
         out_valid   <= 1'b1;
         out_opcode  <= emit_long ? op_q : in_byte;
         out_operand <= emit_long ? word_next : '0;
         out_len     <= emit_len;
         out_addr    <= cur_ip;
      end else if (out_valid && out_ready) begin
         out_valid <= 1'b0;
      end
   end

   assign out_next_ip = out_addr + ADDR_W'(out_len);

endmodule

// File: rtl/vla_assembler_chk.sv
module vla_assembler_chk #(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_ready,
   input logic                  redir_valid,
   input logic [ADDR_W-1:0]     redir_addr,
   input logic                  out_valid,
   input logic                  out_ready,
   input logic [BYTE_W-1:0]     out_opcode,
   input logic [2*BYTE_W-1:0]   out_operand,
   input logic [1:0]            out_len,
   input logic [ADDR_W-1:0]     out_addr,
   input logic [ADDR_W-1:0]     out_next_ip,
   input logic [ADDR_W-1:0]     cur_ip
);

   assert_len_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_len == 2'd1 || out_len == 2'd3));

   assert_ip_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> cur_ip == out_next_ip);

   assert_branch_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_opcode[7:3] == 5'b00001) |-> out_len == 2'd3);

   assert_short_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_len == 2'd1) |-> out_operand == '0);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode) &&
         $stable(out_operand) && $stable(out_len) && $stable(out_addr)));

   assert_no_take_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   assert_redir_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> !in_ready);

   assert_redir_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> cur_ip == $past(redir_addr));

endmodule

bind vla_assembler vla_assembler_chk #(
   .BYTE_W(BYTE_W),
   .ADDR_W(ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_ready   (in_ready),
   .redir_valid(redir_valid),
   .redir_addr (redir_addr),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_opcode (out_opcode),
   .out_operand(out_operand),
   .out_len    (out_len),
   .out_addr   (out_addr),
   .out_next_ip(out_next_ip),
   .cur_ip     (cur_ip)
);

// File: tb/vla_assembler_test.sv
`timescale 1ns/1ps
module vla_assembler_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        in_ready;
   logic        redir_valid = 1'b0;
   logic [15:0] redir_addr = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_opcode;
   logic [15:0] out_operand;
   logic [1:0]  out_len;
   logic [15:0] out_addr;
   logic [15:0] out_next_ip;
   logic [15:0] cur_ip;

   int vectors = 0;
   int errors  = 0;
   logic [15:0] exp_ip;

   always #4 clk = ~clk;

   vla_assembler uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_ready(in_ready), .redir_valid(redir_valid), .redir_addr(redir_addr),
      .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
      .out_operand(out_operand), .out_len(out_len), .out_addr(out_addr),
      .out_next_ip(out_next_ip), .cur_ip(cur_ip)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit exp_long(input int op);
      int cls = op / 32;
      int sub = (op / 8) % 4;
      int sel = op % 8;
      if (cls != 0) return sel >= 5;
      if (sub == 1) return 1'b1;
      if (sub == 2) return sel >= 5;
      return 1'b0;
   endfunction

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic consume();
      @(negedge clk);
      out_ready = 1'b1;
      @(posedge clk);
      #1;
      out_ready = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_byte = 8'hA5;
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 out_valid", 32'(out_valid), 0);
      check("R1 in_ready", 32'(in_ready), 1);
      check("R1 cur_ip", 32'(cur_ip), 0);
      @(negedge clk);
      rst_n = 1'b1;
      exp_ip = 16'h0000;

      // Sweep every opcode
      for (int op = 0; op < 256; op++) begin
         logic [7:0] lo;
         logic [7:0] hi;
         bit         lng;
         string      tag;
         lo  = 8'(op) ^ 8'h5A;
         hi  = 8'(op * 7 + 3);
         lng = exp_long(op);
         tag = (op >= 32) ? "R2" : (((op / 8) % 4) == 1) ? "R3" : "R4";
         push(8'(op));
         check({tag, " length decision"}, 32'(out_valid), 32'(!lng));
         if (lng) begin
            push(lo);
            check("R5 no issue after low byte", 32'(out_valid), 0);
            push(hi);
         end
         check("R6 issued", 32'(out_valid), 1);
         check("R6 opcode", 32'(out_opcode), 32'(op));
         check("R5 operand", 32'(out_operand), lng ? 32'({hi, lo}) : 0);
         check("R6 len", 32'(out_len), lng ? 3 : 1);
         check("R6 addr", 32'(out_addr), 32'(exp_ip));
         check("R6 next_ip", 32'(out_next_ip), 32'(16'(exp_ip + (lng ? 3 : 1))));
         check("R6 cur_ip", 32'(cur_ip), 32'(16'(exp_ip + (lng ? 3 : 1))));
         // Backpressure with junk offered on the input
         in_valid = 1'b1;
         in_byte  = 8'hFF;
         repeat (2) @(posedge clk);
         #1;
         check("R7 held valid", 32'(out_valid), 1);
         check("R7 held opcode", 32'(out_opcode), 32'(op));
         check("R7 held operand", 32'(out_operand), lng ? 32'({hi, lo}) : 0);
         check("R7 in_ready low", 32'(in_ready), 0);
         in_valid = 1'b0;
         consume();
         check("R7 cleared", 32'(out_valid), 0);
         exp_ip = 16'(exp_ip + (lng ? 3 : 1));
      end

      // R9: gaps between bytes, known vector
      push(8'hC6);
      idle(3);
      check("R9 gap no issue", 32'(out_valid), 0);
      push(8'h00);
      idle(4);
      push(8'h10);
      check("R9 gap issue", 32'(out_valid), 1);
      check("R5 C6 00 10 operand", 32'(out_operand), 32'h1000);
      check("R9 addr", 32'(out_addr), 32'(exp_ip));
      consume();
      exp_ip = 16'(exp_ip + 3);

      // R8: redirect mid-instruction
      push(8'hC6);
      push(8'h33);
      @(negedge clk);
      redir_valid = 1'b1;
      redir_addr  = 16'h4000;
      in_valid    = 1'b1;
      in_byte     = 8'h77;
      #1;
      check("R8 in_ready low during redirect", 32'(in_ready), 0);
      @(posedge clk);
      #1;
      redir_valid = 1'b0;
      in_valid    = 1'b0;
      check("R8 cur_ip loaded", 32'(cur_ip), 32'h4000);
      check("R8 no issue", 32'(out_valid), 0);
      push(8'hC6);
      check("R8 restarts at opcode", 32'(out_valid), 0);
      push(8'h00);
      push(8'h20);
      check("R8 issue", 32'(out_valid), 1);
      check("R5 C6 00 20 operand", 32'(out_operand), 32'h2000);
      check("R8 addr", 32'(out_addr), 32'h4000);
      check("R8 next_ip", 32'(out_next_ip), 32'h4003);
      consume();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule